// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block is the host-side control port of an on-chip register file. One set of shared pins carries either an 8-bit parallel bus or a serial bus, chosen by a mode input. In parallel mode a 6-bit address selects a register. Active-low write and read strobes move a byte in or out. In serial mode the same two strobe pins become a serial clock and an active-low chip select. The serial side runs as a 3-wire port, with a data input and a separate data output, or as a 2-wire port, with one bidirectional data pin.

Every write, from either side, lands in a buffer register. The buffer contents reach the active registers that the rest of the chip uses only on a rising edge of a synchronous update input. All external pins are sampled in the system clock domain.

A serial transfer opens with an instruction byte. Bit 7 is the direction, 1 for read and 0 for write, and bits 5:0 hold the start address. Data bytes follow, most significant bit first, and the address steps up after each byte. A serial I/O reset input returns the serial controller to the start of an instruction and leaves the register contents alone.

Top module: `hostreg_port`

## Requirements
- R1: `mode_par` = 1 selects the parallel bus and `mode_par` = 0 selects the serial bus. In serial mode, pulses on the shared strobe pins with chip select high write nothing. Pulling `rd_csn` low in serial mode never drives `pdata_oe`.
- R2: In parallel mode, when `wr_sclk` returns high after a low pulse, `pdata_in` is written to the buffer register at `addr`.
- R3: In parallel mode, while `rd_csn` is low, `pdata_oe` is 1 and `pdata_out` shows the buffer register at `addr`. While `rd_csn` is high, `pdata_oe` is 0.
- R4: Buffer writes leave `act_regs` unchanged. A rising edge of `upd`, sampled on `clk`, copies every buffer register into `act_regs` (byte n at bits 8n+7:8n) on the next clock edge. `act_regs` changes at no other time.
- R5: A serial write samples the data pin on rising `wr_sclk` edges while `rd_csn` is low. The instruction byte has bit 7 = 0 and bits 5:0 = address, and is followed by data bytes MSB first. Each complete data byte is written to the current address, and the address then increments.
- R6: A serial read (bit 7 = 1) drives the byte at the instruction address MSB first, one bit after each falling `wr_sclk` edge. The first bit comes after the falling edge that follows the instruction. Later bytes come from incrementing addresses.
- R7: With `wire2` = 0, read data appears on `sdo`, and `sdio_oe` stays 0.
- R8: With `wire2` = 1, read data appears on `sdio_out` with `sdio_oe` = 1, only during the read data phase with chip select low and serial mode selected. `sdo` stays 0.
- R9: Raising `rd_csn` mid-transaction aborts it. A partial byte is discarded, and the next transaction starts with a fresh instruction byte.
- R10: `io_reset` = 1 returns the serial controller to the instruction phase without changing any buffer or active register.
- R11: After reset, all buffer and active registers are 0 and `pdata_oe`, `sdio_oe` and `sdo` are 0.
- R12: A write to an address at or above `NREG` is ignored. A read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_par | input | 1 | 1 = parallel bus, 0 = serial bus |
| wire2 | input | 1 | Serial variant: 1 = 2-wire, 0 = 3-wire |
| wr_sclk | input | 1 | Parallel write strobe (active low) / serial clock |
| rd_csn | input | 1 | Parallel read strobe (active low) / serial chip select (active low) |
| addr | input | 6 | Parallel register address |
| pdata_in | input | 8 | Parallel write data |
| pdata_out | output | 8 | Parallel read data |
| pdata_oe | output | 1 | Parallel data bus drive enable |
| sdio_in | input | 1 | Serial data in (3-wire input / 2-wire pin input) |
| sdio_out | output | 1 | 2-wire serial data out |
| sdio_oe | output | 1 | 2-wire serial data pin drive enable |
| sdo | output | 1 | 3-wire serial data output |
| io_reset | input | 1 | Serial controller reset, active high |
| upd | input | 1 | Update strobe; rising edge commits buffers |
| act_regs | output | NREG*8 | Active registers, byte n at bits 8n+7:8n |

## Verification
A serial controller that has lost its bit position shows its error as bytes written to the wrong register, or as read data shifted by one or more bits. Either shows up after the next update, or on the first read-back byte. A stuck read phase keeps `sdio_oe` or `sdo` active after chip select rises, and it is caught three clock cycles later. An active register that moves without an update edge is flagged on the edge right after the change. Mode or width confusion shows up as the wrong output carrying the data, or as a strobe that writes nothing.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam int DW = 8;
  localparam int AW = 6;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_WDATA = 2'd1,
    PH_RDATA = 2'd2
  } ser_phase_e;
endpackage

// File: rtl/hrp_rst.sv
module hrp_rst (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int             W  = 1,
  parameter logic [W-1:0]   RV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RV;
      sync_q <= RV;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/hrp_regs.sv
module hrp_regs
  import hrp_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               upd,
  input  logic [AW-1:0]      ra0,
  output logic [DW-1:0]      rd0,
  input  logic [AW-1:0]      ra1,
  output logic [DW-1:0]      rd1,
  output logic [NREG*DW-1:0] act_flat
);
  localparam int          IW  = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [AW:0] LIM = (AW+1)'(NREG);

  logic [DW-1:0] buf_q [NREG];
  logic [DW-1:0] act_q [NREG];
  logic          upd_q;
  logic          commit;
  logic          wr_hit;

  always_comb begin
    commit = upd & ~upd_q;
    wr_hit = wr_en && ({1'b0, wr_addr} < LIM);
    rd0    = ({1'b0, ra0} < LIM) ? buf_q[ra0[IW-1:0]] : '0;
    rd1    = ({1'b0, ra1} < LIM) ? buf_q[ra1[IW-1:0]] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= upd;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 buf_q[g] <= '0;
      else if (wr_hit && (wr_addr[IW-1:0] == IW'(g))) buf_q[g] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      act_q[g] <= '0;
      else if (commit) act_q[g] <= buf_q[g];
    end

    assign act_flat[g*DW +: DW] = act_q[g];
  end
endmodule

// File: rtl/hrp_par.sv
module hrp_par
  import hrp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wrn_s,
  input  logic          rdn_s,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] dout,
  output logic          oe
);
  logic wrn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wrn_q <= 1'b1;
    else        wrn_q <= wrn_s;
  end

  always_comb begin
    wr_en   = en & wrn_s & ~wrn_q;
    wr_addr = addr;
    wr_data = din;
    oe      = en & ~rdn_s;
    dout    = oe ? rd_data : '0;
  end
endmodule

// File: rtl/hrp_ser.sv
module hrp_ser
  import hrp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wire2,
  input  logic          sclk_s,
  input  logic          csn_s,
  input  logic          sdin_s,
  input  logic          io_reset,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sdo,
  output logic          sdio_out,
  output logic          sdio_oe
);
  ser_phase_e    phase_q, phase_n;
  logic [2:0]    bit_q, bit_n;
  logic [DW-1:0] shin_q, shin_n, shin_shift;
  logic [DW-1:0] shout_q, shout_n;
  logic [AW-1:0] addr_q, addr_n;
  logic          obit_q, obit_n;
  logic          sclk_q;
  logic          rise, fall, abort, rd_active;

  always_comb begin
    rise       = sclk_s & ~sclk_q;
    fall       = ~sclk_s & sclk_q;
    abort      = ~en | csn_s | io_reset;
    shin_shift = {shin_q[DW-2:0], sdin_s};
    rd_addr    = (phase_q == PH_INSTR) ? shin_shift[AW-1:0] : addr_q + AW'(1);
    wr_addr    = addr_q;
    wr_data    = shin_shift;

    phase_n = phase_q;
    bit_n   = bit_q;
    shin_n  = shin_q;
    shout_n = shout_q;
    addr_n  = addr_q;
    obit_n  = obit_q;
    wr_en   = 1'b0;

    if (abort) begin
      phase_n = PH_INSTR;
      bit_n   = 3'd0;
      obit_n  = 1'b0;
    end else begin
      if (rise) begin
        shin_n = shin_shift;
        bit_n  = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          case (phase_q)
            PH_INSTR: begin
              addr_n = shin_shift[AW-1:0];
              if (shin_shift[DW-1]) begin
                phase_n = PH_RDATA;
                shout_n = rd_data;
                obit_n  = 1'b0;
              end else begin
                phase_n = PH_WDATA;
              end
            end
            PH_WDATA: begin
              wr_en  = 1'b1;
              addr_n = addr_q + AW'(1);
            end
            PH_RDATA: begin
              shout_n = rd_data;
              addr_n  = addr_q + AW'(1);
            end
            default: phase_n = PH_INSTR;
          endcase
        end
      end
      if (fall && (phase_q == PH_RDATA)) begin
        obit_n  = shout_q[DW-1];
        shout_n = {shout_q[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INSTR;
      bit_q   <= 3'd0;
      shin_q  <= '0;
      shout_q <= '0;
      addr_q  <= '0;
      obit_q  <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      bit_q   <= bit_n;
      shin_q  <= shin_n;
      shout_q <= shout_n;
      addr_q  <= addr_n;
      obit_q  <= obit_n;
      sclk_q  <= sclk_s;
    end
  end

  always_comb begin
    rd_active = (phase_q == PH_RDATA) & ~csn_s & en;
    sdio_oe   = wire2 & rd_active;
    sdio_out  = obit_q;
    sdo       = ~wire2 & rd_active & obit_q;
  end
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
  import hrp_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_par,
  input  logic               wire2,
  input  logic               wr_sclk,
  input  logic               rd_csn,
  input  logic [5:0]         addr,
  input  logic [7:0]         pdata_in,
  output logic [7:0]         pdata_out,
  output logic               pdata_oe,
  input  logic               sdio_in,
  output logic               sdio_out,
  output logic               sdio_oe,
  output logic               sdo,
  input  logic               io_reset,
  input  logic               upd,
  output logic [NREG*8-1:0]  act_regs
);
  logic          rst_i;
  logic          wr_s, cs_s, sdin_s;
  logic          p_we, s_we, we;
  logic [AW-1:0] p_wa, s_wa, wa, s_ra;
  logic [DW-1:0] p_wd, s_wd, wd, p_rd, s_rd;

  hrp_rst u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i));

  hrp_sync #(.W(3), .RV(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_i),
    .d({wr_sclk, rd_csn, sdio_in}),
    .q({wr_s, cs_s, sdin_s})
  );

  hrp_par u_par (
    .clk(clk), .rst_n(rst_i), .en(mode_par),
    .wrn_s(wr_s), .rdn_s(cs_s), .addr(addr), .din(pdata_in),
    .rd_data(p_rd), .wr_en(p_we), .wr_addr(p_wa), .wr_data(p_wd),
    .dout(pdata_out), .oe(pdata_oe)
  );

  hrp_ser u_ser (
    .clk(clk), .rst_n(rst_i), .en(~mode_par), .wire2(wire2),
    .sclk_s(wr_s), .csn_s(cs_s), .sdin_s(sdin_s), .io_reset(io_reset),
    .rd_data(s_rd), .rd_addr(s_ra), .wr_en(s_we), .wr_addr(s_wa),
    .wr_data(s_wd), .sdo(sdo), .sdio_out(sdio_out), .sdio_oe(sdio_oe)
  );

  always_comb begin
    we = mode_par ? p_we : s_we;
    wa = mode_par ? p_wa : s_wa;
    wd = mode_par ? p_wd : s_wd;
  end

  hrp_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_i),
    .wr_en(we), .wr_addr(wa), .wr_data(wd), .upd(upd),
    .ra0(addr), .rd0(p_rd), .ra1(s_ra), .rd1(s_rd),
    .act_flat(act_regs)
  );
endmodule

// File: rtl/hostreg_port_chk.sv
module hostreg_port_chk #(
  parameter int NREG = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_par,
  input logic              wire2,
  input logic              rd_csn,
  input logic              upd,
  input logic              pdata_oe,
  input logic              sdio_oe,
  input logic              sdo,
  input logic [NREG*8-1:0] act_regs
);
  // R1: the parallel and serial sides never drive at the same time
  assert_oe_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(pdata_oe && sdio_oe));

  // R8: the bidirectional pin is driven only in 2-wire serial mode
  assert_sdio_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (wire2 && !mode_par));

  // R9: three cycles of chip select high leave no serial output active
  assert_cs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_csn, 3) && $past(rd_csn, 2) && $past(rd_csn)) |-> (!sdio_oe && !sdo));

  // R4: active registers move only right after an update rising edge
  assert_act_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_regs) |-> ($past(upd) && !$past(upd, 2)));
endmodule

bind hostreg_port hostreg_port_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .wire2(wire2),
  .rd_csn(rd_csn), .upd(upd), .pdata_oe(pdata_oe), .sdio_oe(sdio_oe),
  .sdo(sdo), .act_regs(act_regs)
);

// File: tb/hostreg_port_test.sv
module hostreg_port_test;
  localparam int NREG = 16;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n, mode_par, wire2, wr_sclk, rd_csn, sdio_in, io_reset, upd;
  logic [5:0] addr;
  logic [7:0] pdata_in, pdata_out;
  logic pdata_oe, sdio_out, sdio_oe, sdo;
  logic [NREG*8-1:0] act_regs;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [NREG];

  // address in [13:8], data in [7:0]
  localparam logic [13:0] PVEC [6] = '{
    {6'd0,  8'h11}, {6'd1,  8'h22}, {6'd2,  8'h33},
    {6'd15, 8'hF0}, {6'd20, 8'h99}, {6'd9,  8'h5C}
  };

  always #10 clk = ~clk;

  hostreg_port #(.NREG(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .wire2(wire2),
    .wr_sclk(wr_sclk), .rd_csn(rd_csn), .addr(addr), .pdata_in(pdata_in),
    .pdata_out(pdata_out), .pdata_oe(pdata_oe), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .io_reset(io_reset),
    .upd(upd), .act_regs(act_regs)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NREG*8-1:0] packed_model();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic par_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; pdata_in = d; wr_sclk = 1'b0;
    wait_n(4); wr_sclk = 1'b1; wait_n(6);
    if (a < NREG) model[a] = d;
  endtask

  task automatic par_read(input logic [5:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); addr = a; rd_csn = 1'b0;
    wait_n(5); d = pdata_out; oe = pdata_oe;
    rd_csn = 1'b1; wait_n(5);
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd = 1'b1; wait_n(3); upd = 1'b0; wait_n(2);
  endtask

  task automatic ser_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); sdio_in = b[i];
      wait_n(HALF); wr_sclk = 1'b1; wait_n(HALF); wr_sclk = 1'b0;
    end
  endtask

  task automatic ser_recv(output logic [7:0] b, output logic oe_all, output logic oe_any, output logic sdo_any);
    oe_all = 1'b1; oe_any = 1'b0; sdo_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wait_n(HALF);
      b[i] = wire2 ? sdio_out : sdo;
      oe_all = oe_all & sdio_oe;
      oe_any = oe_any | sdio_oe;
      sdo_any = sdo_any | sdo;
      wr_sclk = 1'b1; wait_n(HALF); wr_sclk = 1'b0;
    end
  endtask

  task automatic cs_low();
    @(negedge clk); rd_csn = 1'b0; wait_n(4);
  endtask

  task automatic cs_high();
    @(negedge clk); rd_csn = 1'b1; wait_n(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rb, rb2;
    logic oe, oe_all, oe_any, sdo_any;
    logic [NREG*8-1:0] snap;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    rst_n = 1'b0; mode_par = 1'b1; wire2 = 1'b0; wr_sclk = 1'b1; rd_csn = 1'b1;
    sdio_in = 1'b0; io_reset = 1'b0; upd = 1'b0; addr = '0; pdata_in = '0;
    wait_n(5); rst_n = 1'b1; wait_n(5);

    // R11: reset state
    check("R11 act_regs", act_regs, '0);
    check("R11 quiet outputs", {pdata_oe, sdio_oe, sdo}, 3'b000);

    // Table-driven parallel writes (R2)
    for (int i = 0; i < 6; i++) par_write(PVEC[i][13:8], PVEC[i][7:0]);
    check("R4 no commit before update", act_regs, '0);

    // Parallel read-back (R3, R12)
    for (int i = 0; i < 6; i++) begin
      logic [7:0] exp;
      exp = (PVEC[i][13:8] < NREG) ? PVEC[i][7:0] : 8'h00;
      par_read(PVEC[i][13:8], rb, oe);
      check("R2/R12 parallel read data", rb, exp);
      check("R3 oe during read", oe, 1'b1);
    end
    check("R3 oe idle", pdata_oe, 1'b0);

    pulse_upd();
    check("R4 commit all", act_regs, packed_model());
    snap = act_regs;

    // R1: serial mode, strobes with chip select high do nothing
    @(negedge clk); mode_par = 1'b0; wr_sclk = 1'b0; wait_n(6);
    addr = 6'd0; pdata_in = 8'hEE;
    for (int k = 0; k < 3; k++) begin
      wr_sclk = 1'b1; wait_n(HALF); wr_sclk = 1'b0; wait_n(HALF);
    end
    cs_low();
    check("R1 no parallel drive in serial mode", pdata_oe, 1'b0);
    cs_high();

    // R5: 3-wire serial write, two bytes from address 3
    cs_low(); ser_bits(8'h03, 8); ser_bits(8'hA1, 8); ser_bits(8'hB2, 8); cs_high();
    model[3] = 8'hA1; model[4] = 8'hB2;
    check("R4 serial writes stay buffered", act_regs, snap);

    // R6, R7: 3-wire serial read with auto-increment
    cs_low(); ser_bits(8'h83, 8);
    ser_recv(rb, oe_all, oe_any, sdo_any);
    ser_recv(rb2, oe_all, oe, sdo_any);
    cs_high();
    check("R6 read first byte", rb, 8'hA1);
    check("R6 read incremented byte", rb2, 8'hB2);
    check("R7 no sdio drive in 3-wire", {oe_any, oe}, 2'b00);

    // R8: 2-wire serial read
    wire2 = 1'b1;
    cs_low(); ser_bits(8'h84, 8);
    ser_recv(rb, oe_all, oe_any, sdo_any);
    cs_high();
    check("R8 2-wire read data", rb, 8'hB2);
    check("R8 sdio driven each bit", oe_all, 1'b1);
    check("R8 sdo quiet in 2-wire", sdo_any, 1'b0);
    check("R8 release after cs high", sdio_oe, 1'b0);
    wire2 = 1'b0;

    // R9: abort mid-instruction and mid-data byte
    cs_low(); ser_bits(8'h00, 3); cs_high();
    cs_low(); ser_bits(8'h05, 8); ser_bits(8'hFF, 4); cs_high();
    cs_low(); ser_bits(8'h06, 8); ser_bits(8'h5A, 8); cs_high();
    model[6] = 8'h5A;

    // R10: io_reset mid-instruction, chip select kept low
    cs_low(); ser_bits(8'hC7, 3);
    @(negedge clk); io_reset = 1'b1; wait_n(4); io_reset = 1'b0; wait_n(2);
    ser_bits(8'h07, 8); ser_bits(8'h77, 8); cs_high();
    model[7] = 8'h77;

    // R12: serial write above NREG is dropped
    cs_low(); ser_bits(8'h30, 8); ser_bits(8'hCC, 8); cs_high();

    // Back to parallel, commit, compare everything
    @(negedge clk); wr_sclk = 1'b1; wait_n(6); mode_par = 1'b1; wait_n(4);
    check("R4 act unchanged without update", act_regs, snap);
    pulse_upd();
    check("R4/R5/R9/R10/R12 committed image", act_regs, packed_model());
    check("R9 partial byte discarded", act_regs[5*8 +: 8], 8'h00);
    check("R10 register kept across io_reset", act_regs[3*8 +: 8], 8'hA1);
    par_read(6'd7, rb, oe);
    check("R10 write after io_reset", rb, 8'h77);
    par_read(6'd48, rb, oe);
    check("R12 out-of-range read", rb, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule